// File: doc/BRIEF.md
# Hardware Barrier Synchronization Unit

This block lets a fixed group of hardware threads or cores meet at a common point before any of them continues. Each requester raises its own request line when it reaches the barrier. The block accepts one request per clock cycle, chosen by fixed priority. It counts accepted arrivals and keeps a shared release flag. When every member of the group has arrived, the block tells all of them in the same cycle that they may go on.

The flag follows the counter-and-flag scheme that software barriers use, here built in hardware. The first arrival of an episode finds the counter at zero and clears the flag. The arrival that brings the count up to the group size sets the flag and returns the counter to zero in the same step. The block is then ready for the next episode at once. A requester that arrives again before it has been released is flagged as a protocol error, and its request is otherwise ignored.

Top module: `barrier_sync_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count, release flag, waiting bits and error bit all become 0. With no requests pending, `arrive_grant` and `release_o` are 0.
- R2: `arrive_grant` has at most one bit set. In the same cycle it selects the lowest-index requester whose request is high and whose waiting bit is clear.
- R3: Each granted arrival that does not complete the episode raises `count_o` by exactly one at the next clock edge. Without a grant, `count_o` keeps its value.
- R4: A granted arrival that finds `count_o` at 0 clears `flag_o` at the next clock edge.
- R5: A granted arrival that finds `count_o` at NUM_REQ-1 completes the episode. At the next clock edge `count_o` becomes 0 and `flag_o` becomes 1.
- R6: A granted requester's bit in `waiting_o` is set at the next clock edge. In the cycle after an episode completes, `release_o` equals the waiting bits, which are all ones. In the cycle after that, both `release_o` and `waiting_o` are 0.
- R7: A request that loses arbitration is not counted. It stays pending while held high and is granted in a later cycle, with no arrival lost.
- R8: A request from a requester whose waiting bit is set is never granted and leaves `count_o` unchanged. It sets `dup_err_o`, which stays 1 until reset.
- R9: `flag_o` stays 1 between episodes until the first arrival of the next episode. Episodes may follow one another with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive_req | input | NUM_REQ | Per-requester arrival request, held until granted |
| arrive_grant | output | NUM_REQ | One-hot grant of the arrival accepted this cycle |
| release_o | output | NUM_REQ | One-cycle release pulse to each waiting requester |
| waiting_o | output | NUM_REQ | Requesters that have arrived and are not yet released |
| flag_o | output | 1 | Shared release flag |
| count_o | output | CNT_W | Arrivals accepted in the current episode |
| dup_err_o | output | 1 | Sticky error: a requester arrived while still waiting |

## Verification
The assertions assume that NUM_REQ is at least 2. They also assume that each requester follows the protocol: it holds its request until granted, drops it in the cycle after the grant, and raises it again only after its release pulse. Under these conditions the error bit stays 0 and each requester arrives once per episode. The directed stimulus keeps to this protocol in every scenario but one. In that scenario a requester re-raises its request while waiting, on purpose, to exercise the error path; the checker's properties hold for that case too.

// File: rtl/barrier_pkg.sv
// Package: shared helpers for the barrier synchronization unit.
// Assumes: group sizes are small positive integers.
package barrier_pkg;

    // Width needed to hold a count from 0 up to and including p.
    function automatic int count_bits(input int p);
        return (p < 2) ? 1 : $clog2(p + 1);
    endfunction

endpackage

// File: rtl/barrier_arbiter.sv
// Module: fixed-priority arbiter. Grants the lowest-index eligible request.
// Assumes: requests are already filtered for eligibility; purely combinational.
module barrier_arbiter #(
    parameter int NUM_REQ = 4
) (
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] grant
);

    logic [NUM_REQ:0] taken;

    assign taken[0] = 1'b0;

    // Priority chain: a request wins only if no lower index asked.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_chain
        assign grant[i]     = req[i] & ~taken[i];
        assign taken[i + 1] = taken[i] | req[i];
    end

endmodule

// File: rtl/barrier_counter.sv
// Module: episode arrival counter and shared release flag.
// Assumes: at most one accepted arrival per cycle (accept is a single bit).
module barrier_counter #(
    parameter int NUM_REQ = 4,
    parameter int CNT_W   = barrier_pkg::count_bits(NUM_REQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             done_pulse
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_REQ - 1);

    logic is_first;
    logic is_last;

    assign is_first = (count == '0);
    assign is_last  = (count == LAST);

    // Count arrivals; wrap to zero on the completing arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (accept) begin
            count <= is_last ? '0 : count + CNT_W'(1);
        end
    end

    // Flag: cleared by the first arrival, set by the completing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (accept && is_last) begin
            flag <= 1'b1;
        end else if (accept && is_first) begin
            flag <= 1'b0;
        end
    end

    // One-cycle marker that the flag was raised at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_pulse <= 1'b0;
        end else begin
            done_pulse <= accept && is_last;
        end
    end

endmodule

// File: rtl/barrier_tracker.sv
// Module: per-requester waiting bits, release pulses and duplicate-arrival error.
// Assumes: grant is one-hot or zero and only covers eligible requesters.
module barrier_tracker #(
    parameter int NUM_REQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req,
    input  logic [NUM_REQ-1:0] grant,
    input  logic               done_pulse,
    output logic [NUM_REQ-1:0] eligible,
    output logic [NUM_REQ-1:0] waiting,
    output logic [NUM_REQ-1:0] release_p,
    output logic               dup_err
);

    logic [NUM_REQ-1:0] dup_hit;

    assign eligible  = req & ~waiting;
    assign dup_hit   = req & waiting;
    assign release_p = done_pulse ? waiting : '0;

    // Waiting bits: set on grant, cleared after the release pulse.
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_wait
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                waiting[i] <= 1'b0;
            end else if (grant[i]) begin
                waiting[i] <= 1'b1;
            end else if (release_p[i]) begin
                waiting[i] <= 1'b0;
            end
        end
    end

    // Sticky error on any request from a requester still waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dup_err <= 1'b0;
        end else if (|dup_hit) begin
            dup_err <= 1'b1;
        end
    end

endmodule

// File: rtl/barrier_sync_unit.sv
// Module: top of the barrier unit. Arbitrates arrivals, counts an episode,
// drives the shared flag and pulses release to all waiting requesters.
// Assumes: NUM_REQ >= 2; requesters hold a request until granted.
module barrier_sync_unit #(
    parameter int NUM_REQ = 4,
    parameter int CNT_W   = barrier_pkg::count_bits(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] arrive_req,
    output logic [NUM_REQ-1:0] arrive_grant,
    output logic [NUM_REQ-1:0] release_o,
    output logic [NUM_REQ-1:0] waiting_o,
    output logic               flag_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               dup_err_o
);

    logic [NUM_REQ-1:0] eligible;
    logic               done_pulse;

    barrier_arbiter #(.NUM_REQ(NUM_REQ)) u_arb (
        .req   (eligible),
        .grant (arrive_grant)
    );

    barrier_counter #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (|arrive_grant),
        .count      (count_o),
        .flag       (flag_o),
        .done_pulse (done_pulse)
    );

    barrier_tracker #(.NUM_REQ(NUM_REQ)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (arrive_req),
        .grant      (arrive_grant),
        .done_pulse (done_pulse),
        .eligible   (eligible),
        .waiting    (waiting_o),
        .release_p  (release_o),
        .dup_err    (dup_err_o)
    );

endmodule

// File: rtl/barrier_sync_checker.sv
// Module: property checker for barrier_sync_unit, attached by bind.
// Assumes: NUM_REQ >= 2.
module barrier_sync_checker #(
    parameter int NUM_REQ = 4,
    parameter int CNT_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] arrive_req,
    input logic [NUM_REQ-1:0] arrive_grant,
    input logic [NUM_REQ-1:0] release_o,
    input logic [NUM_REQ-1:0] waiting_o,
    input logic               flag_o,
    input logic [CNT_W-1:0]   count_o,
    input logic               dup_err_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_REQ - 1);

    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arrive_grant));

    a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_grant & ~arrive_req) == '0);

    a_r8_no_grant_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_grant & waiting_o) == '0);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err_o |=> dup_err_o);

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (|arrive_grant && count_o != LAST) |=> count_o == $past(count_o) + CNT_W'(1));

    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (arrive_grant == '0) |=> $stable(count_o));

    a_r4_first_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|arrive_grant && count_o == '0) |=> !flag_o);

    a_r5_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (|arrive_grant && count_o == LAST) |=> (count_o == '0 && flag_o));

    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= LAST);

    a_r6_release_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o & ~waiting_o) == '0);

    a_r6_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|release_o) |=> (release_o == '0 && waiting_o == '0));

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && arrive_grant == '0) |=> flag_o);

endmodule

bind barrier_sync_unit barrier_sync_checker #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arrive_req   (arrive_req),
    .arrive_grant (arrive_grant),
    .release_o    (release_o),
    .waiting_o    (waiting_o),
    .flag_o       (flag_o),
    .count_o      (count_o),
    .dup_err_o    (dup_err_o)
);

// File: tb/test_barrier_sync_unit.sv
// Bench: directed scenarios for barrier_sync_unit, one task per scenario.
module test_barrier_sync_unit;

    localparam int CLK_PERIOD = 10;
    localparam int P  = 4;
    localparam int CW = barrier_pkg::count_bits(P);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [P-1:0]  arrive_req;
    logic [P-1:0]  arrive_grant;
    logic [P-1:0]  release_o;
    logic [P-1:0]  waiting_o;
    logic          flag_o;
    logic [CW-1:0] count_o;
    logic          dup_err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    barrier_sync_unit #(.NUM_REQ(P)) i_barrier_sync_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .arrive_req   (arrive_req),
        .arrive_grant (arrive_grant),
        .release_o    (release_o),
        .waiting_o    (waiting_o),
        .flag_o       (flag_o),
        .count_o      (count_o),
        .dup_err_o    (dup_err_o)
    );

    // Compare one value and log a failure line.
    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one request at the falling edge and hold it until the grant.
    // Returns at the falling edge after the accepting clock edge.
    task automatic arrive_one(input int id, input string req);
        @(negedge clk);
        arrive_req[id] = 1'b1;
        #1 check(req, "grant", 32'(arrive_grant), 32'(1) << id);
        @(negedge clk);
        arrive_req[id] = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        arrive_req = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "count", 32'(count_o), 0);
        check("R1", "flag", 32'(flag_o), 0);
        check("R1", "waiting", 32'(waiting_o), 0);
        check("R1", "err", 32'(dup_err_o), 0);
        check("R1", "grant", 32'(arrive_grant), 0);
        check("R1", "release", 32'(release_o), 0);
        rst_n = 1'b1;
    endtask

    // One arrival at a time in a scrambled order.
    task automatic t_serial_episode;
        int order[4] = '{2, 0, 3, 1};
        logic [P-1:0] exp_wait = '0;
        for (int k = 0; k < P; k++) begin
            arrive_one(order[k], "R2");
            exp_wait[order[k]] = 1'b1;
            if (k < P - 1) begin
                check("R3", "count", 32'(count_o), 32'(k + 1));
                check("R6", "waiting", 32'(waiting_o), 32'(exp_wait));
                check("R6", "no release yet", 32'(release_o), 0);
            end
        end
        check("R5", "count wrap", 32'(count_o), 0);
        check("R5", "flag set", 32'(flag_o), 1);
        check("R6", "release all", 32'(release_o), 32'((1 << P) - 1));
        @(negedge clk);
        #1;
        check("R6", "release ends", 32'(release_o), 0);
        check("R6", "waiting cleared", 32'(waiting_o), 0);
        repeat (3) @(negedge clk);
        #1 check("R9", "flag held idle", 32'(flag_o), 1);
    endtask

    // All requesters arrive together; losers hold their request.
    task automatic t_simultaneous;
        @(negedge clk);
        arrive_req = '1;
        for (int k = 0; k < P; k++) begin
            #1 check("R2", "priority grant", 32'(arrive_grant), 32'(1) << k);
            if (k == 1) check("R4", "first clears flag", 32'(flag_o), 0);
            if (k > 0) check("R7", "count while held", 32'(count_o), 32'(k));
            @(negedge clk);
            arrive_req[k] = 1'b0;
        end
        #1;
        check("R7", "all counted", 32'(flag_o), 1);
        check("R6", "release all", 32'(release_o), 32'((1 << P) - 1));
    endtask

    // Next episode starts at once after the release cycle.
    task automatic t_back_to_back;
        @(negedge clk);
        #1 check("R9", "flag before next", 32'(flag_o), 1);
        arrive_one(3, "R9");
        check("R4", "flag cleared", 32'(flag_o), 0);
        check("R9", "count new", 32'(count_o), 1);
        arrive_one(1, "R9");
        arrive_one(0, "R9");
        arrive_one(2, "R9");
        check("R9", "second done", 32'(flag_o), 1);
        check("R9", "release", 32'(release_o), 32'((1 << P) - 1));
        @(negedge clk);
    endtask

    // A waiting requester asks again: ignored, error raised.
    task automatic t_duplicate;
        arrive_one(1, "R2");
        check("R8", "err before", 32'(dup_err_o), 0);
        @(negedge clk);
        arrive_req[1] = 1'b1;
        #1 check("R8", "dup not granted", 32'(arrive_grant), 0);
        @(negedge clk);
        arrive_req[1] = 1'b0;
        #1;
        check("R8", "count unchanged", 32'(count_o), 1);
        check("R8", "err set", 32'(dup_err_o), 1);
        arrive_one(0, "R8");
        arrive_one(2, "R8");
        arrive_one(3, "R8");
        check("R8", "episode still completes", 32'(release_o), 32'((1 << P) - 1));
        repeat (2) @(negedge clk);
        #1 check("R8", "err sticky", 32'(dup_err_o), 1);
    endtask

    initial begin
        t_reset();
        t_serial_episode();
        t_simultaneous();
        t_back_to_back();
        t_duplicate();
        t_reset();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule